// File: doc/BRIEF.md
# Link Auto-Negotiation Sequencer

This block is the digital sequencer that settles the operating mode of a 10/100 Ethernet physical-layer device. It hands a 16-bit link code word to a pulse encoder, takes the partner's decoded words from a pulse decoder, and moves through ability detection, acknowledgement and completion. When it completes, it reports the highest mode both sides support. Software reaches four registers through a plain read/write port: control, advertisement, the latched partner word and a status word.

Negotiation restarts on a hardware reset, a software reset, release from power-down, a falling link indication, or a write of the restart bit. Editing the advertisement alone changes nothing on the wire. The new abilities are used only from the next restart onward.

Link code word layout, used in both directions: bits [4:0] hold the selector 5'b00001, bit 5 means 10M half-duplex, bit 6 means 10M full-duplex, bit 7 means 100M half-duplex, bit 8 means 100M full-duplex, and bit 14 is the acknowledge bit. All other bits are sent as 0.

Top module: `an_link_negotiator`

## Requirements
- R1: After reset the sequencer is in ability detection with txEnable high, anDone low, and txWord equal to 16'h01E1 (default abilities 4'hF, acknowledge bit clear).
- R2: Register map: address 0 is control, where a write of bit 9 restarts, bit 11 is power-down and bit 15 is software reset; address 4 reads the selector in [4:0] and the writable abilities in [8:5]; address 5 is the partner word; address 31 is status, with [0] full duplex, [1] 100M, [2] done and [3] fault. Other addresses read 0.
- R3: A write to address 4 leaves the current negotiation and txWord untouched. The new abilities appear in txWord only after the next restart.
- R4: Negotiation restarts (anDone low, acknowledge bit clear) on a restart-bit write, a software reset (which also restores default abilities), the release of power-down, or a 1-to-0 change of linkUp.
- R5: Control bit 9 reads 1 in the cycle after it is written and clears itself on the following edge, when the restart takes place.
- R6: A match needs three consecutive partner words that are identical when bit 14 is ignored. Any differing word starts the count again.
- R7: The resolved mode is the highest common ability in this order: 100M full, 100M half, 10M full, 10M half.
- R8: A match with no common ability sets pdFault (status bit 3) and stays in ability detection. A later good match clears pdFault.
- R9: After a match, txWord carries the acknowledge bit. Three matching partner words with bit 14 set complete the negotiation and raise anDone.
- R10: In the acknowledge phase, a partner word whose content (bit 14 ignored) differs from the matched word restarts negotiation.
- R11: In the acknowledge phase, a gap of WINDOW cycles with no partner word restarts negotiation.
- R12: On a match, the partner word is latched into address 5. The resolved speed and duplex appear on speed100/fullDuplex and in status. txEnable is low once done.
- R13: While power-down is set, the sequencer is idle with txEnable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| linkUp | input | 1 | Link status from the link monitor |
| rxWordValid | input | 1 | One-cycle strobe for a decoded partner word |
| rxWord | input | 16 | Decoded partner link code word |
| txEnable | output | 1 | Encoder should send bursts |
| txWord | output | 16 | Local link code word to send |
| anDone | output | 1 | Negotiation complete |
| speed100 | output | 1 | Resolved speed is 100M |
| fullDuplex | output | 1 | Resolved mode is full duplex |
| pdFault | output | 1 | Last match had no common ability |

## Verification
The assertions assume that rxWordValid is a single-cycle strobe with rxWord stable while it is high, and that register writes go only to the defined addresses. They also assume a restart bit is not written again in the same cycle as power-down. The directed bench drives every partner word as an isolated one-cycle pulse at the falling edge, with idle cycles between pulses. Register writes are issued only while no partner word is in flight, so each check sees a single cause.

// File: rtl/an_link_pkg.sv
package an_link_pkg;
  localparam int WORD_W = 16;
  localparam logic [4:0] SELECTOR = 5'b00001;
  localparam int ACK_BIT = 14;
  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_ADV = 5'd4;
  localparam logic [4:0] REG_PARTNER = 5'd5;
  localparam logic [4:0] REG_STATUS = 5'd31;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DETECT,
    ST_ACK,
    ST_DONE
  } anState_t;

  typedef struct packed {
    logic restart;
    logic accept;
    logic fault;
    logic finish;
    logic inDetect;
    logic inAck;
  } anStrobe_t;
endpackage

// File: rtl/an_link_datapath.sv
module an_link_datapath
  import an_link_pkg::*;
#(
  parameter logic [3:0] ABIL_DEFAULT = 4'hF,
  parameter int MATCH_NEED = 3,
  parameter int ACK_NEED = 3,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [4:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              linkUp,
  input  logic              rxWordValid,
  input  logic [WORD_W-1:0] rxWord,
  input  anStrobe_t         strb,
  input  logic              anDone,
  output logic              restartReq,
  output logic              powerDown,
  output logic              matchSeen,
  output logic              noCommon,
  output logic              ackMismatch,
  output logic              ackDoneHit,
  output logic              windowExpired,
  output logic [3:0]        txAbility,
  output logic              speed100,
  output logic              fullDuplex,
  output logic              pdFault
);
  localparam int CNT_W = $clog2(MATCH_NEED + 1);
  localparam int ACK_W = $clog2(ACK_NEED + 1);
  localparam int TMR_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] MATCH_LAST = CNT_W'(MATCH_NEED - 1);
  localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACK_NEED - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WINDOW - 1);

  logic [3:0] advAbility, activeAbility;
  logic restartBit, pdPrev, linkPrev;
  logic [WORD_W-2:0] lastKey;
  logic [CNT_W-1:0] sameCnt;
  logic [ACK_W-1:0] ackCnt;
  logic [TMR_W-1:0] timer;
  logic [WORD_W-1:0] partnerWord;
  logic wrCtrl, wrAdv;
  logic [WORD_W-2:0] rxKey, partnerKey;
  logic [3:0] common;

  assign wrCtrl = regWrEn && (regAddr == REG_CTRL);
  assign wrAdv = regWrEn && (regAddr == REG_ADV);
  assign rxKey = {rxWord[WORD_W-1], rxWord[ACK_BIT-1:0]};
  assign partnerKey = {partnerWord[WORD_W-1], partnerWord[ACK_BIT-1:0]};
  assign common = activeAbility & rxWord[8:5];

  assign restartReq = restartBit | (pdPrev & ~powerDown) | (linkPrev & ~linkUp);
  assign matchSeen = strb.inDetect && rxWordValid && (sameCnt == MATCH_LAST) && (rxKey == lastKey);
  assign noCommon = (common == 4'b0000);
  assign ackMismatch = strb.inAck && rxWordValid && (rxKey != partnerKey);
  assign ackDoneHit = strb.inAck && rxWordValid && !ackMismatch && rxWord[ACK_BIT] && (ackCnt == ACK_LAST);
  assign windowExpired = strb.inAck && !rxWordValid && (timer == TMR_LAST);
  assign txAbility = activeAbility;

  // Register-side state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      advAbility <= ABIL_DEFAULT;
      powerDown <= 1'b0;
      restartBit <= 1'b0;
      pdPrev <= 1'b0;
      linkPrev <= 1'b0;
    end else begin
      pdPrev <= powerDown;
      linkPrev <= linkUp;
      if (strb.restart) restartBit <= 1'b0;
      if (wrCtrl) begin
        if (regWrData[15]) begin
          advAbility <= ABIL_DEFAULT;
          powerDown <= 1'b0;
          restartBit <= 1'b1;
        end else begin
          powerDown <= regWrData[11];
          if (regWrData[9]) restartBit <= 1'b1;
        end
      end
      if (wrAdv) advAbility <= regWrData[8:5];
    end
  end

  // Negotiation-side state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeAbility <= ABIL_DEFAULT;
      lastKey <= '0;
      sameCnt <= '0;
      ackCnt <= '0;
      timer <= '0;
      partnerWord <= '0;
      speed100 <= 1'b0;
      fullDuplex <= 1'b0;
      pdFault <= 1'b0;
    end else if (strb.restart) begin
      activeAbility <= advAbility;
      sameCnt <= '0;
      ackCnt <= '0;
      timer <= '0;
      speed100 <= 1'b0;
      fullDuplex <= 1'b0;
      pdFault <= 1'b0;
    end else begin
      if (strb.inDetect && rxWordValid) begin
        lastKey <= rxKey;
        sameCnt <= (sameCnt != '0 && rxKey == lastKey) ? sameCnt + 1'b1 : CNT_W'(1);
      end
      if (strb.fault) begin
        pdFault <= 1'b1;
        sameCnt <= '0;
      end
      if (strb.accept) begin
        partnerWord <= rxWord;
        pdFault <= 1'b0;
        speed100 <= common[3] | common[2];
        fullDuplex <= common[3] | (~common[2] & common[1]);
        ackCnt <= '0;
        timer <= '0;
        sameCnt <= '0;
      end
      if (strb.inAck) begin
        if (rxWordValid) begin
          timer <= '0;
          if (!ackMismatch && rxWord[ACK_BIT]) ackCnt <= ackCnt + 1'b1;
        end else begin
          timer <= timer + 1'b1;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: begin
        regRdData[9] = restartBit;
        regRdData[11] = powerDown;
      end
      REG_ADV: regRdData = {7'b0, advAbility, SELECTOR};
      REG_PARTNER: regRdData = partnerWord;
      REG_STATUS: regRdData = {12'b0, pdFault, anDone, speed100, fullDuplex};
      default: regRdData = '0;
    endcase
  end

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restartBit && !powerDown && !wrCtrl) |=> !restartBit);
  // R8
  fault_not_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdFault |-> !strb.inAck);
endmodule

// File: rtl/an_link_ctrl.sv
module an_link_ctrl
  import an_link_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerDown,
  input  logic      restartReq,
  input  logic      matchSeen,
  input  logic      noCommon,
  input  logic      ackMismatch,
  input  logic      ackDoneHit,
  input  logic      windowExpired,
  output anStrobe_t strb,
  output logic      anDone,
  output logic      txEnable,
  output logic      txAck
);
  anState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_DETECT;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb = '0;
    strb.inDetect = (state == ST_DETECT);
    strb.inAck = (state == ST_ACK);
    if (powerDown) begin
      nextState = ST_IDLE;
    end else if (restartReq || state == ST_IDLE) begin
      nextState = ST_DETECT;
      strb.restart = 1'b1;
    end else begin
      case (state)
        ST_DETECT: begin
          if (matchSeen) begin
            if (noCommon) begin
              strb.fault = 1'b1;
            end else begin
              strb.accept = 1'b1;
              nextState = ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (ackMismatch || windowExpired) begin
            strb.restart = 1'b1;
            nextState = ST_DETECT;
          end else if (ackDoneHit) begin
            strb.finish = 1'b1;
            nextState = ST_DONE;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  assign anDone = (state == ST_DONE);
  assign txEnable = (state == ST_DETECT) || (state == ST_ACK);
  assign txAck = (state == ST_ACK);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.restart, strb.accept, strb.fault, strb.finish}));
  // R6
  ack_from_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && $past(state) != ST_ACK) |-> $past(state) == ST_DETECT);
  // R9
  done_from_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && $past(state) != ST_DONE) |-> $past(state) == ST_ACK);
endmodule

// File: rtl/an_link_negotiator.sv
module an_link_negotiator
  import an_link_pkg::*;
#(
  parameter logic [3:0] ABIL_DEFAULT = 4'hF,
  parameter int MATCH_NEED = 3,
  parameter int ACK_NEED = 3,
  parameter int WINDOW = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [4:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        linkUp,
  input  logic        rxWordValid,
  input  logic [15:0] rxWord,
  output logic        txEnable,
  output logic [15:0] txWord,
  output logic        anDone,
  output logic        speed100,
  output logic        fullDuplex,
  output logic        pdFault
);
  anStrobe_t strb;
  logic restartReq, powerDown, matchSeen, noCommon;
  logic ackMismatch, ackDoneHit, windowExpired, txAck;
  logic [3:0] txAbility;

  an_link_datapath #(
    .ABIL_DEFAULT(ABIL_DEFAULT), .MATCH_NEED(MATCH_NEED),
    .ACK_NEED(ACK_NEED), .WINDOW(WINDOW)
  ) dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .linkUp(linkUp),
    .rxWordValid(rxWordValid), .rxWord(rxWord), .strb(strb), .anDone(anDone),
    .restartReq(restartReq), .powerDown(powerDown), .matchSeen(matchSeen),
    .noCommon(noCommon), .ackMismatch(ackMismatch), .ackDoneHit(ackDoneHit),
    .windowExpired(windowExpired), .txAbility(txAbility), .speed100(speed100),
    .fullDuplex(fullDuplex), .pdFault(pdFault)
  );

  an_link_ctrl ctrl (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .restartReq(restartReq),
    .matchSeen(matchSeen), .noCommon(noCommon), .ackMismatch(ackMismatch),
    .ackDoneHit(ackDoneHit), .windowExpired(windowExpired), .strb(strb),
    .anDone(anDone), .txEnable(txEnable), .txAck(txAck)
  );

  assign txWord = {1'b0, txAck, 5'b0, txAbility, SELECTOR};
endmodule

// File: tb/tb_an_link_negotiator.sv
module tb_an_link_negotiator;
  localparam int WIN = 64;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic linkUp = 1'b0;
  logic rxWordValid = 1'b0;
  logic [15:0] rxWord = '0;
  logic txEnable, anDone, speed100, fullDuplex, pdFault;
  logic [15:0] txWord;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  an_link_negotiator #(.WINDOW(WIN)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .linkUp(linkUp),
    .rxWordValid(rxWordValid), .rxWord(rxWord), .txEnable(txEnable),
    .txWord(txWord), .anDone(anDone), .speed100(speed100),
    .fullDuplex(fullDuplex), .pdFault(pdFault)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk);
    rxWordValid = 1'b1; rxWord = w;
    @(negedge clk);
    rxWordValid = 1'b0;
  endtask

  task automatic negotiate(input logic [15:0] w);
    for (int i = 0; i < 3; i++) sendWord(w);
    for (int i = 0; i < 3; i++) sendWord(w | 16'h4000);
  endtask

  task automatic doRestart();
    regWrite(5'd0, 16'h0200);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 anDone", {15'b0, anDone}, 16'h0);
    chk("R1 txEnable", {15'b0, txEnable}, 16'h1);
    chk("R1 txWord", txWord, 16'h01E1);
    regRead(5'd4, d); chk("R2 adv reg", d, 16'h01E1);
    regRead(5'd31, d); chk("R2 status reg", d, 16'h0000);
    regRead(5'd7, d); chk("R2 unmapped reg", d, 16'h0000);
  endtask

  task automatic t_full();
    logic [15:0] d;
    sendWord(16'h01E1); sendWord(16'h01E1);
    chk("R6 no match after two", txWord, 16'h01E1);
    sendWord(16'h01E1);
    chk("R9 ack sent", txWord, 16'h41E1);
    regRead(5'd5, d); chk("R12 partner latched", d, 16'h01E1);
    sendWord(16'h41E1); sendWord(16'h41E1);
    chk("R9 not done after two acks", {15'b0, anDone}, 16'h0);
    sendWord(16'h41E1);
    chk("R9 done", {15'b0, anDone}, 16'h1);
    chk("R7 100FD", {14'b0, speed100, fullDuplex}, 16'h3);
    chk("R12 txEnable low when done", {15'b0, txEnable}, 16'h0);
    regRead(5'd31, d); chk("R12 status", d, 16'h0007);
  endtask

  task automatic t_advNoRestart();
    logic [15:0] d;
    regWrite(5'd4, 16'h0021);
    chk("R3 still done", {15'b0, anDone}, 16'h1);
    regRead(5'd4, d); chk("R2 adv written", d, 16'h0021);
    regWrite(5'd0, 16'h0200);
    regRead(5'd0, d); chk("R5 restart bit set", d, 16'h0200);
    chk("R5 not yet restarted", {15'b0, anDone}, 16'h1);
    @(negedge clk);
    regRead(5'd0, d); chk("R5 restart bit cleared", d, 16'h0000);
    chk("R4 restarted", {15'b0, anDone}, 16'h0);
    chk("R3 new ability used", txWord, 16'h0021);
  endtask

  task automatic t_noCommon();
    logic [15:0] d;
    for (int i = 0; i < 3; i++) sendWord(16'h0181);
    chk("R8 fault", {15'b0, pdFault}, 16'h1);
    chk("R8 stays detect", txWord, 16'h0021);
    regRead(5'd31, d); chk("R8 status fault", d, 16'h0008);
    for (int i = 0; i < 3; i++) sendWord(16'h0021);
    chk("R8 match after fault", txWord, 16'h4021);
    chk("R8 fault cleared", {15'b0, pdFault}, 16'h0);
    for (int i = 0; i < 3; i++) sendWord(16'h4021);
    chk("R7 10HD", {13'b0, anDone, speed100, fullDuplex}, 16'h4);
  endtask

  task automatic t_priority();
    regWrite(5'd4, 16'h01E0);
    doRestart();
    negotiate(16'h00A1);
    chk("R7 100HD", {13'b0, anDone, speed100, fullDuplex}, 16'h6);
    doRestart();
    negotiate(16'h0061);
    chk("R7 10FD", {13'b0, anDone, speed100, fullDuplex}, 16'h5);
  endtask

  task automatic t_mismatch();
    doRestart();
    for (int i = 0; i < 3; i++) sendWord(16'h01E1);
    chk("R9 in ack", txWord, 16'h41E1);
    sendWord(16'h41A1);
    chk("R10 restart on change", txWord, 16'h01E1);
  endtask

  task automatic t_counterReset();
    sendWord(16'h01E1); sendWord(16'h01E1); sendWord(16'h0161); sendWord(16'h01E1);
    chk("R6 broken run", txWord, 16'h01E1);
    sendWord(16'h01E1); sendWord(16'h41E1);
    chk("R6 ack bit ignored in match", txWord, 16'h41E1);
  endtask

  task automatic t_timeout();
    repeat (WIN + 4) @(negedge clk);
    chk("R11 window expiry", txWord, 16'h01E1);
  endtask

  task automatic t_link();
    negotiate(16'h01E1);
    chk("R9 done before link loss", {15'b0, anDone}, 16'h1);
    @(negedge clk); linkUp = 1'b1;
    @(negedge clk);
    chk("R4 link up holds done", {15'b0, anDone}, 16'h1);
    linkUp = 1'b0;
    @(negedge clk);
    chk("R4 link loss restarts", {15'b0, anDone}, 16'h0);
  endtask

  task automatic t_powerDown();
    regWrite(5'd0, 16'h0800);
    @(negedge clk);
    chk("R13 idle tx off", {15'b0, txEnable}, 16'h0);
    regWrite(5'd0, 16'h0000);
    @(negedge clk);
    chk("R4 power-down release", {15'b0, txEnable}, 16'h1);
  endtask

  task automatic t_softReset();
    logic [15:0] d;
    regWrite(5'd4, 16'h0021);
    doRestart();
    chk("R3 restart uses adv", txWord, 16'h0021);
    regWrite(5'd0, 16'h8000);
    regRead(5'd4, d); chk("R4 soft reset default adv", d, 16'h01E1);
    @(negedge clk);
    chk("R4 soft reset restarts", txWord, 16'h01E1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_advNoRestart();
    t_noCommon();
    t_priority();
    t_mismatch();
    t_counterReset();
    t_timeout();
    t_link();
    t_powerDown();
    t_softReset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule